// File: doc/BRIEF.md
# Vectored Context Switch Sequencer

This block carries out a processor context switch. A request names a kind (interrupt level, extended operation or restart), a number from 0 to 15 and, for an extended operation, an effective operand address. The block fetches a two-word transfer vector from memory. The first word becomes the new workspace pointer and the second word becomes the new program counter. It then writes the old machine state into fixed registers of the new sixteen-word workspace in memory. There is no stack.

The block holds the workspace pointer, program counter and status word. It reaches memory through a simple synchronous word-wide port and signals the end of each switch with a one-cycle done pulse. Instruction decode, priority arbitration between interrupt sources and the return from a context are handled elsewhere.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset, wpOut, pcOut and stOut are zero, and busy and done are low.
- R2: reqType encodes the request kind: 0 is an interrupt level, 1 is an extended operation and 2 is a restart. The vector starts at byte address 4*reqNum for an interrupt level, at 0x0040 + 4*reqNum for an extended operation, and at 0xFFFC for a restart. The second vector word is read at the start address + 2.
- R3: The first vector word becomes wpOut and the second becomes pcOut. Both change only during a switch, in the same cycle, after all saving writes are done.
- R4: The pre-switch WP, PC and ST are written to registers 13, 14 and 15 of the new workspace, in that order. Register k is at byte address newWP + 2*k.
- R5: An extended operation also writes reqEa to register 11 of the new workspace. Other kinds leave register 11 untouched.
- R6: An extended operation sets the X flag, stOut[9] (bit 6 when the status word is counted from its MSB as bit 0). X is set one cycle after the cycle in which WP and PC change. Other kinds leave stOut unchanged.
- R7: Bit 0 of memAddr is always zero while memReq is high, even when the loaded WP is odd.
- R8: A memory access holds memReq, memWe, memAddr and memWdata steady until a rising clock edge at which memReady is high. That edge completes the transfer, and memRdata is sampled at it.
- R9: busy rises the cycle after a request is accepted. done is high for exactly one cycle per switch, while busy is still high, and busy falls the next cycle.
- R10: A request presented while busy is high is ignored. No second switch follows.
- R11: A request with reqType 3 is ignored. busy stays low and WP, PC and ST do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqType | input | 2 | Request kind (see R2, R11) |
| reqNum | input | 4 | Level or operation number |
| reqEa | input | 16 | Effective address for an extended operation |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Byte address, word aligned |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data |
| memReady | input | 1 | Access completes at this edge |
| wpOut | output | 16 | Workspace pointer |
| pcOut | output | 16 | Program counter |
| stOut | output | 16 | Status word |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 16-bit words, 4-bit request numbers, the extended-operation table at 0x0040, the restart vector at 0xFFFC and the X flag at bit 9. With these values it can reach the lowest and highest vector slots of both tables and the restart slot, in a chain of switches where each saved WP, PC and ST is the state left by the previous switch. Its memory model inserts zero to three wait cycles per access, which exercises the hold rule. An odd workspace pointer exercises the alignment rule.

// File: rtl/ctx_switch_pkg.sv
package ctx_switch_pkg;

  // Request kinds as carried on reqType
  typedef enum logic [1:0] {
    KIND_LEVEL   = 2'd0,
    KIND_XOP     = 2'd1,
    KIND_RESTART = 2'd2,
    KIND_NONE    = 2'd3
  } req_kind_e;

  // What the datapath puts on the memory address/data lines
  typedef enum logic [2:0] {
    SEL_VEC_LO,
    SEL_VEC_HI,
    SEL_SAVE_WP,
    SEL_SAVE_PC,
    SEL_SAVE_ST,
    SEL_SAVE_EA
  } addr_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      latchReq;
    logic      capWp;
    logic      capPc;
    logic      commit;
    logic      setX;
    addr_sel_e sel;
  } ctl_strobes_t;

  // Workspace register slots that receive saved state
  localparam int SLOT_OLD_WP = 13;
  localparam int SLOT_OLD_PC = 14;
  localparam int SLOT_OLD_ST = 15;
  localparam int SLOT_EA     = 11;

endpackage

// File: rtl/ctx_vector_map.sv
module ctx_vector_map
  import ctx_switch_pkg::*;
#(
  parameter int                WORD_W       = 16,
  parameter int                NUM_W        = 4,
  parameter logic [WORD_W-1:0] XOP_BASE     = 16'h0040,
  parameter logic [WORD_W-1:0] RESTART_ADDR = 16'hFFFC
) (
  input  logic [1:0]        kind,
  input  logic [NUM_W-1:0]  num,
  output logic [WORD_W-1:0] base
);

  localparam int PAD_W = WORD_W - NUM_W - 2;

  logic [WORD_W-1:0] slotOff;

  // Each vector is two words, so the slot offset is num * 4
  assign slotOff = {{PAD_W{1'b0}}, num, 2'b00};

  always_comb begin
    case (req_kind_e'(kind))
      KIND_XOP:     base = XOP_BASE + slotOff;
      KIND_RESTART: base = RESTART_ADDR;
      default:      base = slotOff;
    endcase
  end

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
  import ctx_switch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqType,
  input  logic         memReady,
  output ctl_strobes_t ctl,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_WP, S_RD_PC, S_WR_WP, S_WR_PC, S_WR_ST,
    S_WR_EA, S_COMMIT, S_MARKX, S_FINISH
  } state_e;

  state_e state, nextState;
  logic   xopFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      xopFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.latchReq) xopFlag <= (req_kind_e'(reqType) == KIND_XOP);
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.sel   = SEL_VEC_LO;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid && (req_kind_e'(reqType) != KIND_NONE)) begin
          ctl.latchReq = 1'b1;
          nextState    = S_RD_WP;
        end
      end
      S_RD_WP: begin
        memReq  = 1'b1;
        ctl.sel = SEL_VEC_LO;
        if (memReady) begin
          ctl.capWp = 1'b1;
          nextState = S_RD_PC;
        end
      end
      S_RD_PC: begin
        memReq  = 1'b1;
        ctl.sel = SEL_VEC_HI;
        if (memReady) begin
          ctl.capPc = 1'b1;
          nextState = S_WR_WP;
        end
      end
      S_WR_WP: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_SAVE_WP;
        if (memReady) nextState = S_WR_PC;
      end
      S_WR_PC: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_SAVE_PC;
        if (memReady) nextState = S_WR_ST;
      end
      S_WR_ST: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_SAVE_ST;
        if (memReady) nextState = xopFlag ? S_WR_EA : S_COMMIT;
      end
      S_WR_EA: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_SAVE_EA;
        if (memReady) nextState = S_COMMIT;
      end
      S_COMMIT: begin
        ctl.commit = 1'b1;
        nextState  = xopFlag ? S_MARKX : S_FINISH;
      end
      S_MARKX: begin
        ctl.setX  = 1'b1;
        nextState = S_FINISH;
      end
      S_FINISH: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/ctx_switch_dp.sv
module ctx_switch_dp
  import ctx_switch_pkg::*;
#(
  parameter int                WORD_W       = 16,
  parameter int                NUM_W        = 4,
  parameter logic [WORD_W-1:0] XOP_BASE     = 16'h0040,
  parameter logic [WORD_W-1:0] RESTART_ADDR = 16'hFFFC,
  parameter int                XBIT         = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      ctl,
  input  logic [1:0]        reqType,
  input  logic [NUM_W-1:0]  reqNum,
  input  logic [WORD_W-1:0] reqEa,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] wpOut,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] stOut
);

  localparam logic [WORD_W-1:0] ALIGN_MASK = ~WORD_W'(1);
  localparam logic [WORD_W-1:0] WORD_STEP  = WORD_W'(2);

  logic [WORD_W-1:0] wpReg, pcReg, stReg;
  logic [WORD_W-1:0] vecBase, newWp, newPc, eaReg;
  logic [WORD_W-1:0] baseNext;
  logic [WORD_W-1:0] rawAddr;

  function automatic logic [WORD_W-1:0] slotAddr(input logic [WORD_W-1:0] wsBase, input int slot);
    return wsBase + WORD_W'(2 * slot);
  endfunction

  ctx_vector_map #(
    .WORD_W      (WORD_W),
    .NUM_W       (NUM_W),
    .XOP_BASE    (XOP_BASE),
    .RESTART_ADDR(RESTART_ADDR)
  ) u_vecmap (
    .kind(reqType),
    .num (reqNum),
    .base(baseNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpReg   <= '0;
      pcReg   <= '0;
      stReg   <= '0;
      vecBase <= '0;
      newWp   <= '0;
      newPc   <= '0;
      eaReg   <= '0;
    end else begin
      if (ctl.latchReq) begin
        vecBase <= baseNext;
        eaReg   <= reqEa;
      end
      if (ctl.capWp) newWp <= memRdata;
      if (ctl.capPc) newPc <= memRdata;
      if (ctl.commit) begin
        wpReg <= newWp;
        pcReg <= newPc;
      end
      if (ctl.setX) stReg[XBIT] <= 1'b1;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_VEC_HI:  rawAddr = vecBase + WORD_STEP;
      SEL_SAVE_WP: rawAddr = slotAddr(newWp, SLOT_OLD_WP);
      SEL_SAVE_PC: rawAddr = slotAddr(newWp, SLOT_OLD_PC);
      SEL_SAVE_ST: rawAddr = slotAddr(newWp, SLOT_OLD_ST);
      SEL_SAVE_EA: rawAddr = slotAddr(newWp, SLOT_EA);
      default:     rawAddr = vecBase;
    endcase
  end

  assign memAddr = rawAddr & ALIGN_MASK;

  always_comb begin
    case (ctl.sel)
      SEL_SAVE_WP: memWdata = wpReg;
      SEL_SAVE_PC: memWdata = pcReg;
      SEL_SAVE_ST: memWdata = stReg;
      SEL_SAVE_EA: memWdata = eaReg;
      default:     memWdata = '0;
    endcase
  end

  assign wpOut = wpReg;
  assign pcOut = pcReg;
  assign stOut = stReg;

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
  import ctx_switch_pkg::*;
#(
  parameter int                WORD_W       = 16,
  parameter int                NUM_W        = 4,
  parameter logic [WORD_W-1:0] XOP_BASE     = 16'h0040,
  parameter logic [WORD_W-1:0] RESTART_ADDR = 16'hFFFC,
  parameter int                XBIT         = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [NUM_W-1:0]  reqNum,
  input  logic [WORD_W-1:0] reqEa,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic [WORD_W-1:0] wpOut,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] stOut,
  output logic              busy,
  output logic              done
);

  ctl_strobes_t ctl;

  ctx_switch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqType (reqType),
    .memReady(memReady),
    .ctl     (ctl),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .done    (done)
  );

  ctx_switch_dp #(
    .WORD_W      (WORD_W),
    .NUM_W       (NUM_W),
    .XOP_BASE    (XOP_BASE),
    .RESTART_ADDR(RESTART_ADDR),
    .XBIT        (XBIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqType (reqType),
    .reqNum  (reqNum),
    .reqEa   (reqEa),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .wpOut   (wpOut),
    .pcOut   (pcOut),
    .stOut   (stOut)
  );

endmodule

// File: rtl/ctx_switch_seq_chk.sv
module ctx_switch_seq_chk #(
  parameter int WORD_W = 16,
  parameter int XBIT   = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [WORD_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic [WORD_W-1:0] wpOut,
  input logic [WORD_W-1:0] pcOut,
  input logic [WORD_W-1:0] stOut
);

  assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[0] == 1'b0));

  assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_regs_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(wpOut) && $stable(pcOut) && $stable(stOut)));

  assert_x_at_finish_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stOut[XBIT]) |-> done);

  assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

bind ctx_switch_seq ctx_switch_seq_chk #(
  .WORD_W(WORD_W),
  .XBIT  (XBIT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .memReq  (memReq),
  .memWe   (memWe),
  .memReady(memReady),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .wpOut   (wpOut),
  .pcOut   (pcOut),
  .stOut   (stOut)
);

// File: tb/ctx_switch_seq_bench.sv
module ctx_switch_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = 2'd0;
  logic [3:0]  reqNum = 4'd0;
  logic [15:0] reqEa = 16'h0;
  logic        memReq, memWe;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        memReady;
  logic [15:0] wpOut, pcOut, stOut;
  logic        busy, done;

  int testsRun = 0;
  int testsFailed = 0;
  int waitCycles = 0;
  int waitCnt;

  logic        tbWrEn = 1'b0;
  logic [15:0] tbWrAddr = 16'h0;
  logic [15:0] tbWrData = 16'h0;
  logic [15:0] mem [0:4095];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_switch_seq u_ctx_switch_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqNum(reqNum), .reqEa(reqEa), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .wpOut(wpOut), .pcOut(pcOut), .stOut(stOut),
    .busy(busy), .done(done)
  );

  // Memory model: byte address, 13-bit window, configurable wait states
  assign memRdata = mem[memAddr[12:1]];

  always @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      waitCnt  <= 0;
    end else begin
      if (tbWrEn) mem[tbWrAddr[12:1]] <= tbWrData;
      if (memReq && memReady) begin
        if (memWe) mem[memAddr[12:1]] <= memWdata;
        memReady <= 1'b0;
        waitCnt  <= 0;
      end else if (memReq) begin
        if (waitCnt >= waitCycles) memReady <= 1'b1;
        else waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrAddr = a; tbWrData = d;
    @(negedge clk);
    tbWrEn = 1'b0;
  endtask

  function automatic logic [15:0] peek(input logic [15:0] a);
    return mem[a[12:1]];
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fillWorkspace(input logic [15:0] ws);
    poke(ws + 16'd22, 16'hDEAD);
    poke(ws + 16'd26, 16'hDEAD);
    poke(ws + 16'd28, 16'hDEAD);
    poke(ws + 16'd30, 16'hDEAD);
  endtask

  // Issue one request and follow it to completion
  task automatic runSwitch(input logic [1:0] t, input logic [3:0] n,
                           input logic [15:0] ea, input bit pokeBusy,
                           output int doneCnt, output logic xAtLoad);
    logic [15:0] oldWp;
    bit seenLoad;
    bit finished;
    oldWp = wpOut;
    seenLoad = 0;
    finished = 0;
    doneCnt = 0;
    xAtLoad = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqNum = n; reqEa = ea;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (pokeBusy) begin
        reqValid = busy;
        reqType  = 2'd1;
        reqNum   = 4'd2;
        reqEa    = 16'h5555;
      end
      if (!seenLoad && wpOut !== oldWp) begin
        seenLoad = 1;
        xAtLoad  = stOut[9];
      end
      if (done) doneCnt++;
      if (doneCnt > 0 && !done) begin
        finished = 1;
        break;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R9 switch did not complete: actual done count %0d expected 1", doneCnt);
    end
  endtask

  task automatic testReset();
    checkEq("R1", "wp", wpOut, 16'h0000);
    checkEq("R1", "pc", pcOut, 16'h0000);
    checkEq("R1", "st", stOut, 16'h0000);
    checkEq("R1", "busy", {15'd0, busy}, 16'h0);
    checkEq("R1", "done", {15'd0, done}, 16'h0);
  endtask

  task automatic testLevel5();
    int dc; logic xl;
    waitCycles = 0;
    runSwitch(2'd0, 4'd5, 16'hFFFF, 0, dc, xl);
    checkEq("R2", "level5 wp from vector 0x14", wpOut, 16'h0200);
    checkEq("R3", "level5 pc", pcOut, 16'h1234);
    checkEq("R4", "level5 saved wp", peek(16'h021A), 16'h0000);
    checkEq("R4", "level5 saved pc", peek(16'h021C), 16'h0000);
    checkEq("R4", "level5 saved st", peek(16'h021E), 16'h0000);
    checkEq("R5", "level5 r11 untouched", peek(16'h0216), 16'hDEAD);
    checkEq("R6", "level5 st unchanged", stOut, 16'h0000);
    checkEq("R9", "level5 done count", 16'(dc), 16'd1);
  endtask

  task automatic testXop3();
    int dc; logic xl;
    waitCycles = 0;
    runSwitch(2'd1, 4'd3, 16'h0ABC, 0, dc, xl);
    checkEq("R2", "xop3 wp from vector 0x4C", wpOut, 16'h0300);
    checkEq("R3", "xop3 pc", pcOut, 16'h2000);
    checkEq("R4", "xop3 saved wp", peek(16'h031A), 16'h0200);
    checkEq("R4", "xop3 saved pc", peek(16'h031C), 16'h1234);
    checkEq("R4", "xop3 saved st", peek(16'h031E), 16'h0000);
    checkEq("R5", "xop3 r11 ea", peek(16'h0316), 16'h0ABC);
    checkEq("R6", "xop3 X clear when wp changes", {15'd0, xl}, 16'h0);
    checkEq("R6", "xop3 X set at end", stOut, 16'h0200);
    checkEq("R9", "xop3 done count", 16'(dc), 16'd1);
  endtask

  task automatic testRestart();
    int dc; logic xl;
    waitCycles = 2;
    runSwitch(2'd2, 4'd9, 16'h1111, 0, dc, xl);
    checkEq("R2", "restart wp from 0xFFFC", wpOut, 16'h0400);
    checkEq("R3", "restart pc", pcOut, 16'h0F00);
    checkEq("R8", "restart saved wp with waits", peek(16'h041A), 16'h0300);
    checkEq("R4", "restart saved pc", peek(16'h041C), 16'h2000);
    checkEq("R4", "restart saved st", peek(16'h041E), 16'h0200);
    checkEq("R5", "restart r11 untouched", peek(16'h0416), 16'hDEAD);
    checkEq("R6", "restart st unchanged", stOut, 16'h0200);
  endtask

  task automatic testLevel15Odd();
    int dc; logic xl;
    waitCycles = 3;
    runSwitch(2'd0, 4'd15, 16'h0000, 0, dc, xl);
    checkEq("R2", "level15 wp from vector 0x3C", wpOut, 16'h0501);
    checkEq("R3", "level15 pc", pcOut, 16'h0100);
    checkEq("R7", "odd wp save lands at 0x51A", peek(16'h051A), 16'h0400);
    checkEq("R7", "odd wp pc save at 0x51C", peek(16'h051C), 16'h0F00);
    checkEq("R8", "level15 saved st with waits", peek(16'h051E), 16'h0200);
  endtask

  task automatic testXop15();
    int dc; logic xl;
    waitCycles = 1;
    runSwitch(2'd1, 4'd15, 16'h1235, 0, dc, xl);
    checkEq("R2", "xop15 wp from vector 0x7C", wpOut, 16'h0600);
    checkEq("R3", "xop15 pc", pcOut, 16'h0700);
    checkEq("R4", "xop15 saved odd wp", peek(16'h061A), 16'h0501);
    checkEq("R5", "xop15 r11 ea", peek(16'h0616), 16'h1235);
    checkEq("R6", "xop15 st", stOut, 16'h0200);
  endtask

  task automatic testBusyIgnore();
    int dc; logic xl; bit sawBusy;
    waitCycles = 0;
    runSwitch(2'd0, 4'd1, 16'h0000, 1, dc, xl);
    checkEq("R10", "level1 wp", wpOut, 16'h0700);
    checkEq("R10", "level1 pc", pcOut, 16'h0800);
    checkEq("R10", "busy request did not write r11", peek(16'h0716), 16'hDEAD);
    checkEq("R4", "level1 saved wp", peek(16'h071A), 16'h0600);
    sawBusy = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (busy) sawBusy = 1;
    end
    checkEq("R10", "no second switch", {15'd0, sawBusy}, 16'h0);
    checkEq("R10", "wp kept", wpOut, 16'h0700);
  endtask

  task automatic testType3();
    bit sawBusy;
    sawBusy = 0;
    @(negedge clk);
    reqValid = 1'b1; reqType = 2'd3; reqNum = 4'd0; reqEa = 16'h0;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 12; c++) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
    end
    checkEq("R11", "type3 no busy", {15'd0, sawBusy}, 16'h0);
    checkEq("R11", "type3 wp", wpOut, 16'h0700);
    checkEq("R11", "type3 pc", pcOut, 16'h0800);
    checkEq("R11", "type3 st", stOut, 16'h0200);
  endtask

  task automatic testLevel0();
    int dc; logic xl;
    waitCycles = 0;
    runSwitch(2'd0, 4'd0, 16'h0000, 0, dc, xl);
    checkEq("R2", "level0 wp from vector 0x00", wpOut, 16'h0800);
    checkEq("R3", "level0 pc", pcOut, 16'h0900);
    checkEq("R4", "level0 saved pc", peek(16'h081C), 16'h0800);
    checkEq("R9", "level0 done count", 16'(dc), 16'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // vectors
    poke(16'h0014, 16'h0200); poke(16'h0016, 16'h1234);
    poke(16'h004C, 16'h0300); poke(16'h004E, 16'h2000);
    poke(16'hFFFC, 16'h0400); poke(16'hFFFE, 16'h0F00);
    poke(16'h003C, 16'h0501); poke(16'h003E, 16'h0100);
    poke(16'h007C, 16'h0600); poke(16'h007E, 16'h0700);
    poke(16'h0004, 16'h0700); poke(16'h0006, 16'h0800);
    poke(16'h0000, 16'h0800); poke(16'h0002, 16'h0900);
    fillWorkspace(16'h0200);
    fillWorkspace(16'h0300);
    fillWorkspace(16'h0400);
    fillWorkspace(16'h0500);
    fillWorkspace(16'h0600);
    fillWorkspace(16'h0700);
    fillWorkspace(16'h0800);
    testReset();
    testLevel5();
    testXop3();
    testRestart();
    testLevel15Odd();
    testXop15();
    testBusyIgnore();
    testType3();
    testLevel0();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule